// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block runs one DMA channel that walks a linked list of eight-word descriptors held in memory. Software sets the channel enable and the address of the first descriptor through a small register port. It then writes the doorbell register to start the channel.

The sequencer reads the descriptor one word at a time through a request/response memory read port. It checks the valid flag in the first word and passes the transfer parameters to an external data mover. When the mover pulses done, the sequencer performs the write-back that the descriptor asks for. It then flags the completion and follows the next-descriptor pointer. The channel stops, and reports itself halted, at the first descriptor whose valid flag is clear.

The byte-moving engine and the memory write path sit outside this block. Memory writes are single-cycle and always accepted.

Top module: `dma_chain_seq`

Register offsets on `reg_addr`:
- 0: config. Bit 0 is the channel enable.
- 1: descriptor pointer. Reads and writes whole 32-byte-aligned addresses.
- 2: doorbell.
- 3: interrupt. Bit 0 is the pending flag.
- 4: status. Bit 0 is halted, bit 1 is descriptor valid, bit 2 is doorbell pushed.
- 5: remaining byte count.

Descriptor words, at byte offsets 0 to 28: cmd0, cmd1, source address, source mode, destination address, destination mode, status word, next pointer.

## Requirements
- R1: After reset the status, interrupt and byte-count registers read 0, `irq` is low and no memory access is made.
- R2: A doorbell write while the enable bit is 1 and the channel is idle causes eight word reads at pointer+0, +4, … +28, in that order.
- R3: A doorbell write while the enable bit is 0 causes no memory read. It only sets status bit 2.
- R4: A fetched descriptor with cmd0 bit 31 clear stops the channel. Status bit 0 is set and status bit 2 is cleared, with no transfer start and no memory write.
- R5: For a valid descriptor, `xfer_start` pulses for one cycle. At that pulse `xfer_src` is word 2, `xfer_dst` is word 4 and `xfer_bytes` is cmd1 bits 21:0. The channel waits for `xfer_done`.
- R6: cmd0 bits 1:0 select the write to the descriptor's status word at pointer+24. The value 0 writes nothing. The value 1 writes the status register value. The value 2 writes cmd0 with bit 31 cleared. The value 3 writes the remaining byte count returned with `xfer_done`.
- R7: When cmd0 bit 2 is set, cmd0 with bit 31 cleared is written to pointer+0 after the transfer. When bit 2 is clear, the descriptor's first word is left untouched.
- R8: Interrupt register bit 0 is set on every descriptor completion. `irq` is that flag ANDed with cmd0 bit 8 of the last completed descriptor.
- R9: Writing 1 to interrupt register bit 0 clears the pending flag. A completion in the same cycle leaves the flag set.
- R10: The next descriptor is fetched from next-pointer bits 26:0 shifted left by 5.
- R11: Status bit 1 equals cmd0 bit 31 of the descriptor currently loaded.
- R12: The byte-count register returns the remaining count that the mover reported at the last completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_rd | output | 1 | Descriptor word read request |
| mem_wr | output | 1 | Write-back strobe |
| mem_addr | output | ADDR_W | Byte address for read or write |
| mem_wdata | output | 32 | Write-back data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| xfer_start | output | 1 | Start pulse to data mover |
| xfer_cmd | output | 32 | Descriptor cmd0 |
| xfer_src | output | 32 | Source address |
| xfer_src_mode | output | 32 | Source mode word |
| xfer_dst | output | 32 | Destination address |
| xfer_dst_mode | output | 32 | Destination mode word |
| xfer_bytes | output | BC_W | Byte count |
| xfer_done | input | 1 | Mover completion pulse |
| xfer_remain | input | BC_W | Bytes left at completion |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a software clear of the pending flag in exactly the cycle in which a completion sets it.

The bench takes manual control of the mover's done pulse. It counts the fixed number of cycles from done to the completion cycle and places the clear write there. It then reads the flag back, expecting it to remain set.

A long mover delay holds the channel mid-transfer, so that the status register can be read while a valid descriptor is loaded.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_start,
  output logic [31:0]       xfer_cmd,
  output logic [31:0]       xfer_src,
  output logic [31:0]       xfer_src_mode,
  output logic [31:0]       xfer_dst,
  output logic [31:0]       xfer_dst_mode,
  output logic [BC_W-1:0]   xfer_bytes,
  input  logic              xfer_done,
  input  logic [BC_W-1:0]   xfer_remain,
  output logic              irq
);
  localparam int NP_W = ADDR_W - 5;
  localparam logic [2:0] A_CFG = 3'd0, A_PTR = 3'd1, A_DB = 3'd2,
                         A_IRQ = 3'd3, A_STAT = 3'd4, A_BCNT = 3'd5;
  localparam logic [2:0] S_IDLE = 3'd0, S_FETCH = 3'd1, S_CHECK = 3'd2,
                         S_XFER = 3'd3, S_WBACK = 3'd4, S_INTR = 3'd5,
                         S_NEXT = 3'd6;

  logic [2:0]        st;
  logic [2:0]        idx;
  logic              rd_pend;
  logic              wstep;
  logic              en, db, halted, pend, ie_last;
  logic [ADDR_W-1:0] ptr;
  logic [BC_W-1:0]   remain;
  logic [31:0]       dw [8];

  logic        db_wr, clr_wr, cmd_vld;
  logic [31:0] stat_val, cmd_novld;

  assign db_wr     = reg_wr && reg_addr == A_DB;
  assign clr_wr    = reg_wr && reg_addr == A_IRQ && reg_wdata[0];
  assign cmd_vld   = dw[0][31];
  assign stat_val  = {29'd0, db, cmd_vld, halted};
  assign cmd_novld = {1'b0, dw[0][30:0]};

  assign xfer_start    = st == S_CHECK && cmd_vld;
  assign xfer_cmd      = dw[0];
  assign xfer_src      = dw[2];
  assign xfer_src_mode = dw[3];
  assign xfer_dst      = dw[4];
  assign xfer_dst_mode = dw[5];
  assign xfer_bytes    = dw[1][BC_W-1:0];
  assign irq           = pend && ie_last;

  assign mem_rd = st == S_FETCH && !rd_pend;
  assign mem_wr = st == S_WBACK && (wstep ? dw[0][2] : dw[0][1:0] != 2'd0);

  always_comb begin
    if (st == S_WBACK)
      mem_addr = wstep ? ptr : ptr + ADDR_W'(24);
    else
      mem_addr = ptr + ADDR_W'({idx, 2'b00});
  end

  always_comb begin
    if (wstep) mem_wdata = cmd_novld;
    else begin
      case (dw[0][1:0])
        2'd1:    mem_wdata = stat_val;
        2'd2:    mem_wdata = cmd_novld;
        2'd3:    mem_wdata = 32'(remain);
        default: mem_wdata = 32'd0;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {31'd0, en};
      A_PTR:   reg_rdata = 32'(ptr);
      A_IRQ:   reg_rdata = {31'd0, pend};
      A_STAT:  reg_rdata = stat_val;
      A_BCNT:  reg_rdata = 32'(remain);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      rd_pend <= 1'b0;
      wstep   <= 1'b0;
      en      <= 1'b0;
      db      <= 1'b0;
      halted  <= 1'b0;
      pend    <= 1'b0;
      ie_last <= 1'b0;
      ptr     <= '0;
      remain  <= '0;
      for (int i = 0; i < 8; i++) dw[i] <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CFG) en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_PTR && st == S_IDLE)
        ptr <= {reg_wdata[ADDR_W-1:5], 5'd0};
      if (db_wr) db <= 1'b1;
      if (clr_wr) pend <= 1'b0;

      case (st)
        S_IDLE: if (db_wr && en) begin
          st      <= S_FETCH;
          idx     <= '0;
          rd_pend <= 1'b0;
          halted  <= 1'b0;
        end
        S_FETCH: begin
          if (mem_rd) rd_pend <= 1'b1;
          if (rd_pend && mem_rvalid) begin
            dw[idx] <= mem_rdata;
            rd_pend <= 1'b0;
            idx     <= idx + 3'd1;
            if (idx == 3'd7) st <= S_CHECK;
          end
        end
        S_CHECK: if (cmd_vld) st <= S_XFER;
                 else begin
                   st     <= S_IDLE;
                   halted <= 1'b1;
                   db     <= 1'b0;
                 end
        S_XFER: if (xfer_done) begin
          remain <= xfer_remain;
          wstep  <= 1'b0;
          st     <= S_WBACK;
        end
        S_WBACK: if (!wstep) wstep <= 1'b1;
                 else st <= S_INTR;
        S_INTR: begin
          pend    <= 1'b1;
          ie_last <= dw[0][8];
          st      <= S_NEXT;
        end
        S_NEXT: begin
          ptr     <= {dw[7][NP_W-1:0], 5'd0};
          idx     <= '0;
          rd_pend <= 1'b0;
          st      <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              xfer_start,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              pend,
  input logic              halted,
  input logic [2:0]        st
);
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_rd_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[1:0] == 2'd0);

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_wr_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[4:0] == 5'd24 || mem_addr[4:0] == 5'd0));

  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(reg_wr && reg_addr == 3'd3 && reg_wdata[0])) |=> pend);

  assert_halt_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (st == 3'd0 && !xfer_start && !mem_wr));
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .xfer_start(xfer_start), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend(pend),
  .halted(halted), .st(st)
);

// File: tb/test_dma_chain_seq.sv
`timescale 1ns/1ps
module test_dma_chain_seq;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_rd, mem_wr, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic xfer_start, xfer_done, irq;
  logic [31:0] xfer_cmd, xfer_src, xfer_src_mode, xfer_dst, xfer_dst_mode;
  logic [21:0] xfer_bytes, xfer_remain;

  int checks = 0, fails = 0;
  logic [31:0] mem [256];
  int rd_n = 0, wr_n = 0, st_n = 0;
  logic [31:0] rd_log [64];
  logic [31:0] cap_src, cap_dst;
  logic [21:0] cap_bytes;
  logic auto_en = 1, auto_done = 0, man_done = 0;
  int mover_delay = 3, mcnt = 0;
  logic timed_out = 0;

  assign xfer_done = auto_done | man_done;
  assign xfer_remain = 22'h12;

  always #2 clk = ~clk;

  dma_chain_seq i_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .xfer_start(xfer_start),
    .xfer_cmd(xfer_cmd), .xfer_src(xfer_src), .xfer_src_mode(xfer_src_mode),
    .xfer_dst(xfer_dst), .xfer_dst_mode(xfer_dst_mode), .xfer_bytes(xfer_bytes),
    .xfer_done(xfer_done), .xfer_remain(xfer_remain), .irq(irq));

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[9:2]];
      if (rd_n < 64) rd_log[rd_n] = mem_addr;
      rd_n = rd_n + 1;
    end
    if (mem_wr) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wr_n = wr_n + 1;
    end
    if (xfer_start) begin
      if (st_n == 0) begin
        cap_src = xfer_src; cap_dst = xfer_dst; cap_bytes = xfer_bytes;
      end
      st_n = st_n + 1;
    end
    auto_done <= 1'b0;
    if (xfer_start && auto_en) mcnt <= mover_delay;
    else if (mcnt != 0) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) auto_done <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clear_logs();
    @(negedge clk); rd_n = 0; wr_n = 0; st_n = 0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] c0, input logic [31:0] c1,
                          input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] stat, input int nxt);
    mem[(base >> 2) + 0] = c0;
    mem[(base >> 2) + 1] = c1;
    mem[(base >> 2) + 2] = src;
    mem[(base >> 2) + 3] = 32'h0;
    mem[(base >> 2) + 4] = dst;
    mem[(base >> 2) + 5] = 32'h0;
    mem[(base >> 2) + 6] = stat;
    mem[(base >> 2) + 7] = 32'(nxt >> 5);
  endtask

  task automatic wait_halt(input string req);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd_reg(3'd4, s);
      if (s[0]) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(3'd4, v); chk("R1 status", v, 0);
    rd_reg(3'd3, v); chk("R1 irq reg", v, 0);
    rd_reg(3'd5, v); chk("R1 bytecnt", v, 0);
    chk("R1 irq pin", 32'(irq), 0);
    chk("R1 no reads", rd_n, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    put_desc(32'h40, 32'h0, 0, 0, 0, 0, 32'h80);
    clear_logs();
    wr_reg(3'd1, 32'h40);
    wr_reg(3'd2, 32'h1);
    repeat (20) @(negedge clk);
    chk("R3 no reads when disabled", rd_n, 0);
    rd_reg(3'd4, v); chk("R3 status doorbell only", v, 32'h4);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    clear_logs();
    wr_reg(3'd0, 32'h1);
    wr_reg(3'd2, 32'h1);
    wait_halt("R4 halt timeout");
    chk("R2 read count", rd_n, 8);
    chk("R2 first addr", rd_log[0], 32'h40);
    chk("R2 fourth addr", rd_log[3], 32'h4C);
    chk("R2 last addr", rd_log[7], 32'h5C);
    rd_reg(3'd4, v); chk("R4 status halted", v, 32'h1);
    chk("R4 no start", st_n, 0);
    chk("R4 no writes", wr_n, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    put_desc(32'h40, 32'h8000_0007, 32'h100, 32'h1000, 32'h2000, 32'hDEAD0000, 32'h80);
    put_desc(32'h80, 32'h8000_0102, 32'h40, 32'h3000, 32'h4000, 32'hDEAD0000, 32'hC0);
    put_desc(32'hC0, 32'h0, 0, 0, 0, 32'hDEAD0000, 32'h100);
    clear_logs();
    wr_reg(3'd1, 32'h40);
    wr_reg(3'd2, 32'h1);
    wait_halt("R10 chain halt timeout");
    chk("R10 reads", rd_n, 24);
    chk("R10 second desc addr", rd_log[8], 32'h80);
    chk("R10 third desc addr", rd_log[16], 32'hC0);
    chk("R5 start count", st_n, 2);
    chk("R5 src", cap_src, 32'h1000);
    chk("R5 dst", cap_dst, 32'h2000);
    chk("R5 bytes", 32'(cap_bytes), 32'h100);
    chk("R6 st3 remaining", mem[32'h58 >> 2], 32'h12);
    chk("R7 clear valid", mem[32'h40 >> 2], 32'h0000_0007);
    chk("R6 st2 cmd0", mem[32'h98 >> 2], 32'h0000_0102);
    chk("R7 no clear", mem[32'h80 >> 2], 32'h8000_0102);
    chk("R4 invalid status untouched", mem[32'hD8 >> 2], 32'hDEAD0000);
    rd_reg(3'd3, v); chk("R8 pending", v, 1);
    chk("R8 irq with IE", 32'(irq), 1);
    rd_reg(3'd4, v); chk("R11 status after halt", v, 32'h1);
    rd_reg(3'd5, v); chk("R12 bytecnt", v, 32'h12);
  endtask

  task automatic t_status_modes();
    logic [31:0] v;
    wr_reg(3'd3, 32'h1);
    rd_reg(3'd3, v); chk("R9 w1c clears", v, 0);
    chk("R9 irq low", 32'(irq), 0);
    put_desc(32'h100, 32'h8000_0001, 32'h8, 32'h5000, 32'h6000, 32'hDEAD0000, 32'h140);
    put_desc(32'h140, 32'h8000_0000, 32'h8, 32'h7000, 32'h7800, 32'hDEADBEEF, 32'h180);
    put_desc(32'h180, 32'h0, 0, 0, 0, 32'hDEAD0000, 32'h1C0);
    mover_delay = 20;
    clear_logs();
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd2, 32'h1);
    while (st_n == 0) @(negedge clk);
    rd_reg(3'd4, v); chk("R11 valid during transfer", v, 32'h6);
    wait_halt("R6 halt timeout");
    chk("R6 st1 status value", mem[32'h118 >> 2], 32'h6);
    chk("R6 st0 untouched", mem[32'h158 >> 2], 32'hDEADBEEF);
    chk("R6 write count", wr_n, 1);
    chk("R7 cmd0 kept", mem[32'h100 >> 2], 32'h8000_0001);
    rd_reg(3'd3, v); chk("R8 pending without IE", v, 1);
    chk("R8 irq masked", 32'(irq), 0);
    mover_delay = 3;
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    wr_reg(3'd3, 32'h1);
    put_desc(32'h1C0, 32'h8000_0000, 32'h4, 32'h1, 32'h2, 32'h0, 32'h200);
    put_desc(32'h200, 32'h0, 0, 0, 0, 32'h0, 32'h240);
    auto_en = 0;
    clear_logs();
    wr_reg(3'd1, 32'h1C0);
    wr_reg(3'd2, 32'h1);
    while (st_n == 0) @(negedge clk);
    man_done = 1;
    @(negedge clk); man_done = 0;
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h1;
    @(negedge clk); reg_wr = 0;
    wait_halt("R9 halt timeout");
    rd_reg(3'd3, v); chk("R9 completion beats clear", v, 1);
    wr_reg(3'd3, 32'h1);
    rd_reg(3'd3, v); chk("R9 later clear", v, 0);
    auto_en = 1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        t_reset();
        t_disabled();
        t_invalid();
        t_chain();
        t_status_modes();
        t_clear_race();
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule